// File: doc/BRIEF.md
# Byte-Oriented Two-Wire Bus Master with Lagging Receive Register

This block is an I2C bus master that a processor drives through five byte-wide registers selected by a 3-bit index. Control-register edges produce START, repeated START and STOP. A write to the data register sends one byte with the acknowledge bit. A read of the data register receives one byte. Each finished byte sets a sticky flag, which can raise an interrupt. The clock line and the data line are open-drain: the block only pulls a line low or lets it go, and it reads back the resolved level.

Receive is pipelined by one byte. In receive mode a read of the data register returns the byte captured by the previous bus read and launches the next one. Software therefore reads one dummy byte after addressing a device for reading. Before issuing STOP, software sets the no-acknowledge control bit and performs one final read, so that the last byte on the bus is refused.

Register indices: 0 own address, 1 clock divider, 2 control, 3 status, 4 data. Control bits: 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 no-acknowledge, 2 repeated start. Status bits: 7 byte complete, 5 bus busy, 1 flag, 0 received acknowledge level. All other bits read 0.

Top module: `i2c_lag_master`

## Requirements
- R1: After reset, status reads 0x80, control reads 0x00, `irq` is low, and both `scl_pull` and `sda_pull` are low (lines released).
- R2: While a byte is being shifted, consecutive rising edges of the clock line are 4*(D+1) system clocks apart, where D is the divider register (index 1).
- R3: Writing control with bit 5 set while it was clear issues a START, that is, SDA falls while SCL is high. Writing it clear while set issues a STOP, that is, SDA rises while SCL is high. Status bit 5 goes to 1 once the START is seen on the lines and back to 0 once the STOP is seen.
- R4: With control bit 5 and bit 4 set, writing the data register (index 4) sends that byte MSB first. SDA changes only while SCL is low.
- R5: Status bit 0 holds the SDA level sampled in the 9th bit of the last byte: 0 for an acknowledge, 1 when no device acknowledged.
- R6: At the end of every byte, status bits 7 and 1 are set. Bit 7 reads 0 while a byte is queued or shifting. Bit 1 is cleared only by writing the status register with bit 1 at 0; writing it at 1 leaves it set.
- R7: `irq` is high exactly when status bit 1 and control bit 6 are both set.
- R8: In receive mode (control bit 5 set, bit 4 clear), a data-register read returns the byte captured by the previous receive and launches the next receive. The first such read after reset returns 0x00.
- R9: When control bit 3 is set, a received byte ends with the master leaving SDA high in the 9th bit (no acknowledge), and status bit 0 then reads 1.
- R10: Writing control with bits 5 and 2 set while already master issues a repeated START. Bit 2 always reads back 0.
- R11: A data-register read when not master, or a data-register write in receive mode, starts no bus activity: the flag stays 0 and the data register is unchanged.
- R12: Writing control with bit 7 at 0 aborts any transfer. It releases both lines and clears the master bit, the flag and bus busy.
- R13: The own-address register (index 0) reads back the last value written to it and does not affect bus behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_idx | input | 3 | Register index 0..4 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx` (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Resolved clock line level |
| sda_in | input | 1 | Resolved data line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |

## Verification
A wrong phase counter or bit counter in the shifter shows up within one byte. The bus device model then captures a misaligned byte, or the acknowledge lands in the wrong slot, and status bit 0 reads 1 where 0 was expected. A fault in the lagging receive path shows up on the very next data read, as a value one byte early or one byte late. A stuck flag or busy bit appears at the status register when the bench next polls it, which is at most a few hundred clocks after the byte or STOP that should have changed it.

// File: rtl/i2cl_pkg.sv
package i2cl_pkg;

    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    // register indices
    localparam logic [2:0] IDX_OWN  = 3'd0;
    localparam logic [2:0] IDX_DIV  = 3'd1;
    localparam logic [2:0] IDX_CTL  = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_DAT  = 3'd4;

    // control bit positions
    localparam int CB_EN   = 7;
    localparam int CB_IEN  = 6;
    localparam int CB_MST  = 5;
    localparam int CB_TX   = 4;
    localparam int CB_NAK  = 3;
    localparam int CB_RST  = 2;

    // status bit positions
    localparam int SB_DONE = 7;
    localparam int SB_BUSY = 5;
    localparam int SB_FLAG = 1;
    localparam int SB_ACK  = 0;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_RSTART,
        OP_STOP,
        OP_BYTE
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             rx;
        logic             nack;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_HOLD,
        E_START,
        E_RSTART,
        E_STOP,
        E_BYTE
    } eng_e;

    // 1 means pull SDA low for this bit slot
    function automatic logic sda_low_for(input logic [BCNT_W-1:0] bitn,
                                         input logic rx, input logic nack,
                                         input logic msb);
        logic r;
        if (bitn < BCNT_W'(BYTE_W)) r = rx ? 1'b0 : ~msb;
        else                        r = rx ? ~nack : 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/i2cl_tick_gen.sv
module i2cl_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && en && div != '0) |=> (!tick || div == '0)); // R2

endmodule

// File: rtl/i2cl_bus_mon.sv
module i2cl_bus_mon (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    logic scl_prev, sda_prev;
    logic start_seen, stop_seen;

    always_comb begin
        start_seen = scl_i && scl_prev && sda_prev && !sda_i;
        stop_seen  = scl_i && scl_prev && !sda_prev && sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            busy     <= 1'b0;
        end else begin
            scl_prev <= scl_i;
            sda_prev <= sda_i;
            if (!en)             busy <= 1'b0;
            else if (start_seen) busy <= 1'b1;
            else if (stop_seen)  busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cl_bit_engine.sv
module i2cl_bit_engine
    import i2cl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  cmd_t              cmd,
    output logic              take,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low,
    output logic              sda_low,
    output logic              done,
    output logic              done_rx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_lvl,
    output logic              byte_busy
);
    eng_e               st_q;
    logic [1:0]         q_q;
    logic [BCNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0]  sh_q;
    logic               rx_q, nack_q, ack_q;

    always_comb begin
        take      = en && (cmd.op != OP_NONE) && (st_q == E_IDLE || st_q == E_HOLD);
        byte_busy = (st_q == E_BYTE);
        done_rx   = rx_q;
        rx_byte   = sh_q;
        ack_lvl   = ack_q;
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !en) begin
            st_q    <= E_IDLE;
            q_q     <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            rx_q    <= 1'b0;
            nack_q  <= 1'b0;
            ack_q   <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else if (take) begin
            q_q    <= '0;
            bit_q  <= '0;
            sh_q   <= cmd.data;
            rx_q   <= cmd.rx;
            nack_q <= cmd.nack;
            case (cmd.op)
                OP_START:  if (st_q == E_IDLE) st_q <= E_START;
                OP_RSTART: if (st_q == E_HOLD) st_q <= E_RSTART;
                OP_STOP:   if (st_q == E_HOLD) st_q <= E_STOP;
                OP_BYTE:   if (st_q == E_HOLD) st_q <= E_BYTE;
                default:   ;
            endcase
        end else if (tick && st_q != E_IDLE && st_q != E_HOLD) begin
            q_q <= q_q + 2'd1;
            case (st_q)
                E_START: begin
                    if (q_q == 2'd0) begin scl_low <= 1'b0; sda_low <= 1'b0; end
                    if (q_q == 2'd1) sda_low <= 1'b1;
                    if (q_q == 2'd3) begin scl_low <= 1'b1; st_q <= E_HOLD; end
                end
                E_RSTART: begin
                    if (q_q == 2'd0) sda_low <= 1'b0;
                    if (q_q == 2'd1) scl_low <= 1'b0;
                    if (q_q == 2'd2) sda_low <= 1'b1;
                    if (q_q == 2'd3) begin scl_low <= 1'b1; st_q <= E_HOLD; end
                end
                E_STOP: begin
                    if (q_q == 2'd0) sda_low <= 1'b1;
                    if (q_q == 2'd1) scl_low <= 1'b0;
                    if (q_q == 2'd2) sda_low <= 1'b0;
                    if (q_q == 2'd3) st_q <= E_IDLE;
                end
                E_BYTE: begin
                    if (q_q == 2'd0) sda_low <= sda_low_for(bit_q, rx_q, nack_q, sh_q[BYTE_W-1]);
                    if (q_q == 2'd1) scl_low <= 1'b0;
                    if (q_q == 2'd2) begin
                        if (bit_q < BCNT_W'(BYTE_W)) sh_q <= {sh_q[BYTE_W-2:0], sda_i};
                        else                          ack_q <= sda_i;
                    end
                    if (q_q == 2'd3) begin
                        scl_low <= 1'b1;
                        if (bit_q == BCNT_W'(BYTE_W)) begin
                            st_q <= E_HOLD;
                            done <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    // data line moves only while the clock line is held low during a byte
    AST_SDA_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == E_BYTE && !$stable(sda_low)) |-> (scl_low && $past(scl_low) && !scl_i)); // R4

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_low && !sda_low)); // R12

endmodule

// File: rtl/i2cl_regs.sv
module i2cl_regs
    import i2cl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_idx,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              en,
    output logic [DIV_W-1:0]  div,
    output cmd_t              cmd,
    input  logic              take,
    input  logic              done,
    input  logic              done_rx,
    input  logic [BYTE_W-1:0] done_byte,
    input  logic              done_ack,
    input  logic              byte_busy,
    input  logic              bus_busy
);
    logic [7:0]        own_q;
    logic              ien_q, mst_q, tx_q, nak_q;
    logic              flag_q, ack_q;
    logic [BYTE_W-1:0] rxd_q;
    logic              tc;
    logic              ctl_off_wr, flag_clr_wr;

    always_comb begin
        tc          = !byte_busy && (cmd.op != OP_BYTE);
        irq         = flag_q && ien_q;
        ctl_off_wr  = reg_wr && reg_idx == IDX_CTL && !reg_wdata[CB_EN];
        flag_clr_wr = reg_wr && reg_idx == IDX_STAT && !reg_wdata[SB_FLAG];
        case (reg_idx)
            IDX_OWN:  reg_rdata = own_q;
            IDX_DIV:  reg_rdata = 8'(div);
            IDX_CTL:  reg_rdata = {en, ien_q, mst_q, tx_q, nak_q, 3'b000};
            IDX_STAT: reg_rdata = {tc, 1'b0, bus_busy, 3'b000, flag_q, ack_q};
            IDX_DAT:  reg_rdata = rxd_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            div    <= '0;
            en     <= 1'b0;
            ien_q  <= 1'b0;
            mst_q  <= 1'b0;
            tx_q   <= 1'b0;
            nak_q  <= 1'b0;
            flag_q <= 1'b0;
            ack_q  <= 1'b0;
            rxd_q  <= '0;
            cmd    <= '{op: OP_NONE, rx: 1'b0, nack: 1'b0, data: '0};
        end else begin
            if (take) cmd.op <= OP_NONE;
            if (done && en) begin
                flag_q <= 1'b1;
                ack_q  <= done_ack;
                if (done_rx) rxd_q <= done_byte;
            end
            if (reg_wr) begin
                case (reg_idx)
                    IDX_OWN: own_q <= reg_wdata;
                    IDX_DIV: div   <= reg_wdata[DIV_W-1:0];
                    IDX_CTL: begin
                        en    <= reg_wdata[CB_EN];
                        ien_q <= reg_wdata[CB_IEN];
                        tx_q  <= reg_wdata[CB_TX];
                        nak_q <= reg_wdata[CB_NAK];
                        if (!reg_wdata[CB_EN]) begin
                            mst_q  <= 1'b0;
                            flag_q <= 1'b0;
                            cmd.op <= OP_NONE;
                        end else begin
                            mst_q <= reg_wdata[CB_MST];
                            if (!mst_q && reg_wdata[CB_MST])
                                cmd.op <= OP_START;
                            else if (mst_q && !reg_wdata[CB_MST])
                                cmd.op <= OP_STOP;
                            else if (mst_q && reg_wdata[CB_RST])
                                cmd.op <= OP_RSTART;
                        end
                    end
                    IDX_STAT: if (!reg_wdata[SB_FLAG]) flag_q <= 1'b0;
                    IDX_DAT: if (en && mst_q && tx_q)
                        cmd <= '{op: OP_BYTE, rx: 1'b0, nack: 1'b0, data: reg_wdata};
                    default: ;
                endcase
            end
            if (reg_rd && reg_idx == IDX_DAT && en && mst_q && !tx_q)
                cmd <= '{op: OP_BYTE, rx: 1'b1, nack: nak_q, data: '0};
        end
    end

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && en && !ctl_off_wr) |=> flag_q); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr_wr && !ctl_off_wr) |=> flag_q); // R6

endmodule

// File: rtl/i2c_lag_master.sv
module i2c_lag_master
    import i2cl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_idx,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    logic              en, tick, take, done, done_rx, ack_lvl, byte_busy, bus_busy;
    logic [DIV_W-1:0]  div;
    logic [BYTE_W-1:0] rx_byte;
    cmd_t              cmd;

    i2cl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .en(en), .div(div),
        .cmd(cmd), .take(take), .done(done), .done_rx(done_rx), .done_byte(rx_byte),
        .done_ack(ack_lvl), .byte_busy(byte_busy), .bus_busy(bus_busy)
    );

    i2cl_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .en(en), .div(div), .tick(tick)
    );

    i2cl_bit_engine u_eng (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .cmd(cmd), .take(take),
        .scl_i(scl_in), .sda_i(sda_in), .scl_low(scl_pull), .sda_low(sda_pull),
        .done(done), .done_rx(done_rx), .rx_byte(rx_byte), .ack_lvl(ack_lvl),
        .byte_busy(byte_busy)
    );

    i2cl_bus_mon u_mon (
        .clk(clk), .rst(rst), .en(en), .scl_i(scl_in), .sda_i(sda_in), .busy(bus_busy)
    );

    // a byte only shifts on a bus that the monitor saw claimed
    AST_BYTE_ON_BUSY_BUS: assert property (@(posedge clk) disable iff (rst)
        byte_busy |-> bus_busy); // R3

endmodule

// File: tb/test_i2c_lag_master.sv
`timescale 1ns/1ps
module test_i2c_lag_master;

    localparam logic [6:0] SLV = 7'h3A;
    typedef enum logic [2:0] {M_IDLE, M_ADDR, M_WRITE, M_RPEND, M_READ} smode_e;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_idx = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_pull, sda_pull;
    logic       s_pull;
    logic       scl_line, sda_line;

    int vectors = 0, miscompares = 0, cyc = 0;

    always #2 clk = ~clk;

    assign scl_line = ~scl_pull;
    assign sda_line = ~(sda_pull | s_pull);

    i2c_lag_master i_i2c_lag_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // ---------------- behavioural bus device ----------------
    smode_e     smode;
    logic       ps, pd, mack;
    logic [3:0] scnt, wp, rp;
    logic [7:0] ssr, stx;
    logic [7:0] wmem [0:15];
    logic [7:0] rmem [0:15];
    int         starts, stops, per, lastrise;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            smode <= M_IDLE; ps <= 1'b1; pd <= 1'b1; scnt <= 4'd0; s_pull <= 1'b0;
            wp <= 4'd0; rp <= 4'd0; ssr <= 8'h00; stx <= 8'h00; mack <= 1'b0;
            starts <= 0; stops <= 0; per <= 0; lastrise <= 0;
        end else begin
            ps <= scl_line;
            pd <= sda_line;
            if (scl_line && ps && pd && !sda_line) begin
                smode <= M_ADDR; scnt <= 4'd0; s_pull <= 1'b0; starts <= starts + 1;
            end else if (scl_line && ps && !pd && sda_line) begin
                smode <= M_IDLE; s_pull <= 1'b0; stops <= stops + 1;
            end else if (scl_line && !ps) begin
                if (scnt >= 4'd1 && scnt <= 4'd7 && smode != M_IDLE) per <= cyc - lastrise;
                lastrise <= cyc;
                if (scnt < 4'd8) ssr <= {ssr[6:0], sda_line};
                else if (scnt == 4'd8 && smode == M_READ) mack <= !sda_line;
                scnt <= scnt + 4'd1;
            end else if (!scl_line && ps) begin
                if (scnt == 4'd8) begin
                    case (smode)
                        M_ADDR: if (ssr[7:1] == SLV) begin
                            s_pull <= 1'b1;
                            if (ssr[0]) begin smode <= M_RPEND; rp <= 4'd0; end
                            else        begin smode <= M_WRITE; wp <= 4'd0; end
                        end else smode <= M_IDLE;
                        M_WRITE: begin wmem[wp] <= ssr; wp <= wp + 4'd1; s_pull <= 1'b1; end
                        M_READ:  s_pull <= 1'b0;
                        default: ;
                    endcase
                end else if (scnt == 4'd9) begin
                    scnt <= 4'd0;
                    s_pull <= 1'b0;
                    if (smode == M_RPEND || (smode == M_READ && mack)) begin
                        smode <= M_READ; stx <= rmem[rp]; rp <= rp + 4'd1;
                        s_pull <= !rmem[rp][7];
                    end else if (smode == M_READ) smode <= M_IDLE;
                end else if (scnt >= 4'd1 && scnt <= 4'd7 && smode == M_READ) begin
                    s_pull <= !stx[7 - int'(scnt)];
                end
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] ctl(input logic en, ien, mst, tx, nak, rs);
        return {en, ien, mst, tx, nak, rs, 2'b00};
    endfunction

    function automatic logic [7:0] stat(input logic tc, busy, flag, ack);
        return {tc, 1'b0, busy, 3'b000, flag, ack};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] v);
        @(negedge clk);
        reg_idx = idx; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_idx = idx; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd3, s);
            if (s[1]) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic wait_busy(input logic lvl, input string req);
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd3, s);
            if (s[5] == lvl) return;
        end
        chk(req, int'(!lvl), int'(lvl));
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v, s;
        logic [7:0] sent [0:7];
        int div, nw, nr, seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) rmem[i] = 8'($urandom);
        div = 1 + int'($urandom % 3);
        nw  = 2 + int'($urandom % 3);
        nr  = 2 + int'($urandom % 3);

        idle_cycles(4);
        rst = 1'b0;
        idle_cycles(2);

        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, stat(1, 0, 0, 0));
        rd(3'd2, v); chk("R1 control", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 lines", {scl_pull, sda_pull}, 0);

        // R13 own address
        wr(3'd0, 8'h5A); rd(3'd0, v); chk("R13 own addr", v, 8'h5A);

        // ---- write session ----
        wr(3'd1, 8'(div));
        wr(3'd2, ctl(1, 1, 0, 1, 0, 0));
        wr(3'd2, ctl(1, 1, 1, 1, 0, 0));
        wait_busy(1'b1, "R3 busy after start");
        chk("R3 start seen", starts, 1);
        wr(3'd4, {SLV, 1'b0});
        rd(3'd3, v); chk("R6 done low while shifting", v[7], 0);
        wait_flag("R6 flag after address");
        rd(3'd3, v); chk("R5 ack on address", v[0], 0);
        chk("R7 irq with enable", irq, 1);
        wr(3'd3, 8'h02); rd(3'd3, v); chk("R6 write 1 keeps flag", v[1], 1);
        wr(3'd3, 8'h00); chk("R7 irq after clear", irq, 0);
        for (int k = 0; k < nw; k++) begin
            sent[k] = 8'($urandom);
            if (k == 1) wr(3'd2, ctl(1, 0, 1, 1, 0, 0));
            wr(3'd4, sent[k]);
            wait_flag("R4 byte done");
            rd(3'd3, v); chk("R5 ack on data", v[0], 0);
            if (k == 1) begin
                chk("R7 irq masked", irq, 0);
                wr(3'd2, ctl(1, 1, 1, 1, 0, 0));
            end
            wr(3'd3, 8'h00);
        end
        for (int k = 0; k < nw; k++) chk("R4 byte received", wmem[k], sent[k]);
        chk("R2 scl period", per, 4 * (div + 1));

        // R10 repeated start
        wr(3'd2, ctl(1, 1, 1, 1, 0, 1));
        idle_cycles(40);
        chk("R10 restart seen", starts, 2);
        rd(3'd2, v); chk("R10 bit2 reads 0", v, ctl(1, 1, 1, 1, 0, 0));
        wr(3'd4, {SLV, 1'b0});
        wait_flag("R10 address after restart");
        rd(3'd3, v); chk("R10 ack after restart", v[0], 0);
        wr(3'd3, 8'h00);
        wr(3'd2, ctl(1, 1, 0, 1, 0, 0));
        wait_busy(1'b0, "R3 busy clear after stop");
        chk("R3 stop seen", stops, 1);

        // R5 absent device
        wr(3'd2, ctl(1, 1, 1, 1, 0, 0));
        wait_busy(1'b1, "R3 busy second start");
        wr(3'd4, {~SLV, 1'b0});
        wait_flag("R5 flag no device");
        rd(3'd3, v); chk("R5 no ack", v[0], 1);
        wr(3'd3, 8'h00);
        wr(3'd2, ctl(1, 1, 0, 1, 0, 0));
        wait_busy(1'b0, "R3 busy clear");

        // ---- read session ----
        wr(3'd2, ctl(1, 1, 1, 1, 0, 0));
        wait_busy(1'b1, "R3 busy read start");
        wr(3'd4, {SLV, 1'b1});
        wait_flag("R8 address read");
        rd(3'd3, v); chk("R5 ack read address", v[0], 0);
        wr(3'd3, 8'h00);
        wr(3'd2, ctl(1, 1, 1, 0, 0, 0));
        rd(3'd4, v); chk("R8 first read is dummy", v, 8'h00);
        wait_flag("R8 byte 0");
        wr(3'd3, 8'h00);
        for (int k = 1; k < nr; k++) begin
            rd(3'd4, v); chk("R8 lag one byte", v, rmem[k-1]);
            wait_flag("R8 byte");
            wr(3'd3, 8'h00);
        end
        wr(3'd2, ctl(1, 1, 1, 0, 1, 0));
        rd(3'd4, v); chk("R8 last real byte", v, rmem[nr-1]);
        wait_flag("R9 nack byte");
        rd(3'd3, v); chk("R9 status nack", v[0], 1);
        chk("R9 device saw nack", mack, 0);
        wr(3'd3, 8'h00);
        // R11 data write in receive mode ignored
        wr(3'd4, 8'h55);
        idle_cycles(100);
        rd(3'd3, s); chk("R11 write in rx ignored", s, stat(1, 1, 0, 1));
        wr(3'd2, ctl(1, 1, 0, 0, 0, 0));
        wait_busy(1'b0, "R3 busy clear after read");
        // R11 data read when not master
        rd(3'd4, v); chk("R11 data after stop", v, rmem[nr]);
        idle_cycles(100);
        rd(3'd3, s); chk("R11 no transfer", s, stat(1, 0, 0, 1));
        rd(3'd4, v); chk("R11 data unchanged", v, rmem[nr]);

        // R12 disable mid byte
        wr(3'd2, ctl(1, 1, 1, 1, 0, 0));
        wait_busy(1'b1, "R3 busy before abort");
        wr(3'd4, 8'hA5);
        idle_cycles(20);
        wr(3'd2, 8'h00);
        idle_cycles(2);
        chk("R12 lines released", {scl_pull, sda_pull}, 0);
        rd(3'd3, s); chk("R12 status", s & 8'hA2, 8'h80);
        rd(3'd2, v); chk("R12 control", v, 8'h00);
        chk("R12 irq", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule